// File: doc/BRIEF.md
# Square-Wave Shaper with Programmable Slew

This block turns the phase word of a numerically controlled oscillator into a signed square-wave sample for one output channel. The high portion of each period is set by a 12-bit duty fraction, each transition is a straight-line ramp whose phase width is a power-of-two fraction of a quarter period, and the two plateau levels are plus and minus a signed 16-bit amplitude. The sample is registered, so it follows the phase input by one clock.

A gating enable decides whether the wave is produced or the output is parked at the low level. The enable comes from one of several sources, picked by a 3-bit select: a register bit or one of four external enable inputs, all active high. Duty, slew and amplitude arrive from configuration registers but are staged inside the block. A staged set is replaced only on a trigger pulse, or on any clock while the output was gated off in the previous cycle. Changes made while the wave is running therefore never tear a period in half.

The oscillator, the register bus and the conditioning of the external pins sit outside this block. The block is meant for square-wave mode only, and that mode is selected only while the system is disabled.

Top module: `sqwave_shaper`

## Requirements
- R1: While reset is asserted `sample_o` is 0. Reset also leaves the gate state "off", so the first clock after reset loads the staged parameters.
- R2: With the output gated on, and away from the ramps, a phase `p` (16-bit unsigned) gives `+amp` when `p < duty*16`. Otherwise it gives the low level.
- R3: The rising edge sits at phase 0 and the falling edge at `duty*16`. Each ramp has half-width `h = 2^(13-slew)` phase units. Let `d` be the signed 16-bit wrapped distance from the edge. Where `-h < d < h`, the sample is `floor(amp*d/h)` on the rising edge and `floor(-amp*d/h)` on the falling edge.
- R4: A slew setting above 9 behaves exactly as slew 9.
- R5: A duty of 0 gives the low level at every phase, with no ramps.
- R6: Where the two ramp windows overlap, the rising-edge ramp is used.
- R7: Gate select 0 takes `gate_reg_i`. Values 1 to 4 take `gate_ext_i[sel-1]`. Values 5 to 7 keep the output gated off.
- R8: When the selected enable is low at a clock edge, the next sample is the low level. The low level is `-amp`, saturated to 32767 when `amp` is -32768.
- R9: Duty, slew and amplitude are taken from the inputs at a clock edge only if `trig_i` is high or the gate was off during the previous cycle. Otherwise the staged values hold.
- R10: `sample_o` reflects the phase, enable and parameter inputs present at the preceding clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 16 | Oscillator phase word, unsigned, full scale is one period |
| duty_i | input | 12 | Duty setting, high fraction = value/4096 |
| slew_i | input | 4 | Slew setting, larger is faster, clamped to 9 |
| amp_i | input | 16 | Signed amplitude |
| trig_i | input | 1 | Trigger pulse that loads the staged parameters |
| gate_sel_i | input | 3 | Gating source select |
| gate_reg_i | input | 1 | Register enable bit, used when the select is 0 |
| gate_ext_i | input | 4 | External active-high enables |
| sample_o | output | 16 | Signed output sample |

## Verification
The hardest condition to reach from the ports is a parameter change that must be ignored. The gate has to stay on through a change of duty, slew and amplitude with no trigger, and the phase must then fall between the old and new falling-edge positions so that the held values become visible. The stimulus first loads one set with a trigger. It then presents a different set with the gate held high and sweeps the phase across both edge regions. After that it drops the gate for a single cycle, and finally fires a trigger, comparing every cycle against the reference model. Overlapping ramps at tiny and near-full duties, and the saturated low level at the most negative amplitude, are driven as dedicated sweeps.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  // Region of the period a phase word falls into.
  typedef enum logic [1:0] {
    ZONE_HIGH = 2'd0,
    ZONE_LOW  = 2'd1,
    ZONE_RISE = 2'd2,
    ZONE_FALL = 2'd3
  } zone_e;
endpackage

// File: rtl/sqw_gate_sel.sv
module sqw_gate_sel #(
  parameter int SEL_W = 3,
  parameter int N_EXT = 4
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             reg_en_i,
  input  logic [N_EXT-1:0] ext_en_i,
  output logic             en_o
);
  always_comb begin
    en_o = 1'b0;
    if (sel_i == '0) begin
      en_o = reg_en_i;
    end else begin
      for (int k = 0; k < N_EXT; k++) begin
        if (sel_i == SEL_W'(k + 1)) en_o = ext_en_i[k];
      end
    end
  end
endmodule

// File: rtl/sqw_param_stage.sv
module sqw_param_stage #(
  parameter int DUTY_W   = 12,
  parameter int SLEW_W   = 4,
  parameter int AMP_W    = 16,
  parameter int SLEW_MAX = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [SLEW_W-1:0] slew_i,
  input  logic [AMP_W-1:0]  amp_i,
  output logic [DUTY_W-1:0] duty_n_o,
  output logic [SLEW_W-1:0] slew_n_o,
  output logic [AMP_W-1:0]  amp_n_o
);
  localparam logic [DUTY_W-1:0] DUTY_RST = DUTY_W'(1) << (DUTY_W - 1);
  localparam logic [SLEW_W-1:0] SLEW_LIM = SLEW_W'(SLEW_MAX);

  logic [DUTY_W-1:0] duty_q;
  logic [SLEW_W-1:0] slew_q;
  logic [AMP_W-1:0]  amp_q;
  logic [SLEW_W-1:0] slew_c;

  always_comb begin
    slew_c   = (slew_i > SLEW_LIM) ? SLEW_LIM : slew_i;
    duty_n_o = load_i ? duty_i : duty_q;
    slew_n_o = load_i ? slew_c : slew_q;
    amp_n_o  = load_i ? amp_i  : amp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= DUTY_RST;
      slew_q <= '0;
      amp_q  <= '0;
    end else if (load_i) begin
      duty_q <= duty_n_o;
      slew_q <= slew_n_o;
      amp_q  <= amp_n_o;
    end
  end

  assert_slew_clamped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slew_q <= SLEW_LIM);

  assert_staged_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable({duty_q, slew_q, amp_q}));
endmodule

// File: rtl/sqw_wave_core.sv
module sqw_wave_core
  import sqw_pkg::*;
#(
  parameter int PH_W   = 16,
  parameter int DUTY_W = 12,
  parameter int SLEW_W = 4,
  parameter int AMP_W  = 16
) (
  input  logic [PH_W-1:0]   phase_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [SLEW_W-1:0] slew_i,
  input  logic [AMP_W-1:0]  amp_i,
  output logic [AMP_W-1:0]  wave_o,
  output logic [AMP_W-1:0]  low_o
);
  localparam int SH     = PH_W - DUTY_W;
  localparam int HS_TOP = PH_W - 3;        // log2 of half span at slew 0
  localparam int PW     = AMP_W + PH_W + 1;
  localparam logic [AMP_W-1:0] AMP_MIN = {1'b1, {(AMP_W-1){1'b0}}};
  localparam logic [AMP_W-1:0] AMP_MAX = {1'b0, {(AMP_W-1){1'b1}}};

  logic [PH_W-1:0]        fall_pos, fall_diff;
  logic signed [PH_W:0]   d_rise, d_fall, d_fall_neg, h_span;
  logic signed [PW-1:0]   amp_x, prod_r, prod_f, shr_r, shr_f;
  int                     shamt;
  logic                   in_rise, in_fall;
  zone_e                  zone;

  always_comb begin
    fall_pos   = {duty_i, {SH{1'b0}}};
    fall_diff  = phase_i - fall_pos;
    d_rise     = {phase_i[PH_W-1], phase_i};
    d_fall     = {fall_diff[PH_W-1], fall_diff};
    d_fall_neg = -d_fall;
    shamt      = HS_TOP - int'(slew_i);
    h_span     = (PH_W+1)'(1) << shamt;
    in_rise    = (d_rise > -h_span) && (d_rise < h_span);
    in_fall    = (d_fall > -h_span) && (d_fall < h_span);
    amp_x      = {{(PH_W+1){amp_i[AMP_W-1]}}, amp_i};
    prod_r     = amp_x * {{AMP_W{d_rise[PH_W]}}, d_rise};
    prod_f     = amp_x * {{AMP_W{d_fall_neg[PH_W]}}, d_fall_neg};
    shr_r      = prod_r >>> shamt;
    shr_f      = prod_f >>> shamt;
    low_o      = (amp_i == AMP_MIN) ? AMP_MAX : -amp_i;

    if (duty_i == '0)            zone = ZONE_LOW;
    else if (in_rise)            zone = ZONE_RISE;
    else if (in_fall)            zone = ZONE_FALL;
    else if (phase_i < fall_pos) zone = ZONE_HIGH;
    else                         zone = ZONE_LOW;

    case (zone)
      ZONE_HIGH: wave_o = amp_i;
      ZONE_RISE: wave_o = shr_r[AMP_W-1:0];
      ZONE_FALL: wave_o = shr_f[AMP_W-1:0];
      default:   wave_o = low_o;
    endcase
  end
endmodule

// File: rtl/sqwave_shaper.sv
module sqwave_shaper #(
  parameter int PH_W     = 16,
  parameter int DUTY_W   = 12,
  parameter int SLEW_W   = 4,
  parameter int AMP_W    = 16,
  parameter int SEL_W    = 3,
  parameter int N_EXT    = 4,
  parameter int SLEW_MAX = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PH_W-1:0]   phase_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [SLEW_W-1:0] slew_i,
  input  logic [AMP_W-1:0]  amp_i,
  input  logic              trig_i,
  input  logic [SEL_W-1:0]  gate_sel_i,
  input  logic              gate_reg_i,
  input  logic [N_EXT-1:0]  gate_ext_i,
  output logic [AMP_W-1:0]  sample_o
);
  logic              gate_n, gate_q, load;
  logic [DUTY_W-1:0] duty_n;
  logic [SLEW_W-1:0] slew_n;
  logic [AMP_W-1:0]  amp_n, wave, low_lvl, sample_n;

  sqw_gate_sel #(.SEL_W(SEL_W), .N_EXT(N_EXT)) u_gate (
    .sel_i(gate_sel_i), .reg_en_i(gate_reg_i), .ext_en_i(gate_ext_i), .en_o(gate_n)
  );

  sqw_param_stage #(.DUTY_W(DUTY_W), .SLEW_W(SLEW_W), .AMP_W(AMP_W),
                    .SLEW_MAX(SLEW_MAX)) u_stage (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .duty_i(duty_i), .slew_i(slew_i), .amp_i(amp_i),
    .duty_n_o(duty_n), .slew_n_o(slew_n), .amp_n_o(amp_n)
  );

  sqw_wave_core #(.PH_W(PH_W), .DUTY_W(DUTY_W), .SLEW_W(SLEW_W),
                  .AMP_W(AMP_W)) u_core (
    .phase_i(phase_i), .duty_i(duty_n), .slew_i(slew_n), .amp_i(amp_n),
    .wave_o(wave), .low_o(low_lvl)
  );

  always_comb begin
    load     = trig_i | ~gate_q;
    sample_n = gate_n ? wave : low_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q   <= 1'b0;
      sample_o <= '0;
    end else begin
      gate_q   <= gate_n;
      sample_o <= sample_n;
    end
  end

  assert_gated_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_n |=> sample_o == $past(low_lvl));

  assert_bad_sel_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(gate_sel_i) > N_EXT) |=> sample_o == $past(low_lvl));

  assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_n == '0) |=> sample_o == $past(low_lvl));
endmodule

// File: tb/sqwave_shaper_tb_top.sv
module sqwave_shaper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] phase_i;
  logic [11:0] duty_i;
  logic [3:0]  slew_i;
  logic [15:0] amp_i;
  logic        trig_i;
  logic [2:0]  gate_sel_i;
  logic        gate_reg_i;
  logic [3:0]  gate_ext_i;
  logic [15:0] sample_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  string cur_req = "R2";

  // reference model state
  bit m_gate;
  int m_duty, m_slew, m_amp;

  always #10 clk = ~clk;

  sqwave_shaper dut_i (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .duty_i(duty_i),
    .slew_i(slew_i), .amp_i(amp_i), .trig_i(trig_i), .gate_sel_i(gate_sel_i),
    .gate_reg_i(gate_reg_i), .gate_ext_i(gate_ext_i), .sample_o(sample_o)
  );

  function automatic int wrap16(int x);
    int w;
    w = ((x % 65536) + 65536) % 65536;
    return (w >= 32768) ? w - 65536 : w;
  endfunction

  function automatic int fdiv(longint a, longint b);
    longint q;
    q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return int'(q);
  endfunction

  function automatic int low_of(int amp);
    return (amp == -32768) ? 32767 : -amp;
  endfunction

  function automatic int model_wave(int p, int duty, int slew, int amp);
    int h, hpos, dr, df;
    h    = 1 << (13 - slew);
    hpos = duty * 16;
    if (duty == 0) return low_of(amp);
    dr = wrap16(p);
    if (dr > -h && dr < h) return fdiv(longint'(amp) * dr, h);
    df = wrap16(p - hpos);
    if (df > -h && df < h) return fdiv(-longint'(amp) * df, h);
    if (p < hpos) return amp;
    return low_of(amp);
  endfunction

  function automatic bit model_gate();
    if (gate_sel_i == 3'd0) return gate_reg_i;
    if (gate_sel_i <= 3'd4) return gate_ext_i[gate_sel_i - 3'd1];
    return 1'b0;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: sample actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: model consumes the present inputs, then the DUT output is compared.
  task automatic step(int ph);
    bit g;
    int exp;
    phase_i = 16'(ph);
    g = model_gate();
    if (trig_i || !m_gate) begin
      m_duty = int'(duty_i);
      m_slew = (int'(slew_i) > 9) ? 9 : int'(slew_i);
      m_amp  = int'($signed(amp_i));
    end
    exp = g ? model_wave(ph, m_duty, m_slew, m_amp) : low_of(m_amp);
    m_gate = g;
    @(posedge clk);
    #1;
    check(cur_req, int'($signed(sample_o)), exp);
    trig_i = 1'b0;
  endtask

  task automatic setp(int duty, int slew, int amp, bit trg);
    duty_i = 12'(duty);
    slew_i = 4'(slew);
    amp_i  = 16'(amp);
    trig_i = trg;
  endtask

  task automatic sweep(int start, int stop, int stride);
    for (int p = start; p <= stop; p += stride) step(p & 16'hFFFF);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    phase_i = '0; trig_i = 1'b0; gate_sel_i = '0; gate_reg_i = 1'b0; gate_ext_i = '0;
    setp(100, 0, 5000, 0);
    m_gate = 0; m_duty = 2048; m_slew = 0; m_amp = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'($signed(sample_o)), 0);
    @(negedge clk);
    check("R1", int'($signed(sample_o)), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R2/R3: 50% duty, slew 0, register gate
    cur_req = "R2";
    gate_reg_i = 1'b1;
    setp(2048, 0, 12000, 1);
    sweep(0, 65535, 61);
    cur_req = "R3";
    setp(1000, 5, -7000, 1);
    sweep(-300, 300, 3);
    sweep(16000 - 300, 16000 + 300, 3);
    setp(3333, 9, 32767, 1);
    sweep(53328 - 40, 53328 + 40, 1);
    sweep(-40, 40, 1);

    // R4: slew above 9 clamps
    cur_req = "R4";
    setp(2500, 13, 20000, 1);
    sweep(40000 - 40, 40000 + 40, 1);
    setp(2500, 15, -20000, 1);
    sweep(-40, 40, 1);

    // R5: zero duty
    cur_req = "R5";
    setp(0, 0, 9000, 1);
    sweep(0, 65535, 257);

    // R6: overlapping ramps
    cur_req = "R6";
    setp(3, 0, 15000, 1);
    sweep(-9000, 9000, 41);
    setp(4095, 2, -15000, 1);
    sweep(65520 - 3000, 65520 + 3000, 23);

    // R7: gating sources
    cur_req = "R7";
    setp(1500, 3, 10000, 1);
    for (int s = 0; s < 8; s++) begin
      gate_sel_i = 3'(s);
      for (int i = 0; i < 40; i++) begin
        gate_ext_i = 4'($urandom);
        gate_reg_i = 1'($urandom);
        step(int'($urandom) & 16'hFFFF);
      end
      gate_ext_i = 4'hF;
      gate_reg_i = 1'b1;
      for (int i = 0; i < 10; i++) step(i * 977);
    end

    // R8: gated off with most negative amplitude
    cur_req = "R8";
    gate_sel_i = 3'd0;
    gate_reg_i = 1'b0;
    setp(2048, 4, -32768, 0);
    sweep(0, 65535, 4099);
    gate_reg_i = 1'b1;
    setp(2048, 4, -32768, 1);
    sweep(-1100, 1100, 37);
    sweep(0, 65535, 1999);

    // R9: staged parameters hold while gated on without a trigger
    cur_req = "R9";
    setp(1000, 6, 8000, 1);
    step(0);
    setp(3000, 1, -4000, 0);
    sweep(0, 65535, 111);
    gate_reg_i = 1'b0;
    step(500);
    gate_reg_i = 1'b1;
    sweep(0, 65535, 113);
    setp(700, 8, 2222, 0);
    sweep(10000, 50000, 997);
    trig_i = 1'b1;
    sweep(0, 65535, 127);

    // R10: one-cycle latency with a random phase every cycle
    cur_req = "R10";
    setp(2800, 2, -21000, 1);
    for (int i = 0; i < 400; i++) step(int'($urandom) & 16'hFFFF);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule